// File: doc/BRIEF.md
# Branch Clock Gate Controller

The block holds one configuration register for each branch clock in a set of groups. Each group shares one base clock. Each branch turns its base clock into a stream of clock-enable strobes, all in one base-clock domain. Software controls each branch through three fields: a run control, an automatic power-down control, and a write-only divide-by-two request. It reads back the run and power-down fields and a read-only divider status.

Branch 0 of every group is the group's bus branch. Stopping the bus branch silences every other branch in that group, whatever their own run bits say. A running branch can only be stopped in two steps: first set power-down, then clear run in a later write. A run-clearing write that arrives while power-down is still clear is dropped. An access to a branch whose base clock is switched off is refused with an error and does not change the register. While power-down is set and the branch still runs, the branch's idle input can hold its strobes off. The strobes come back in the same cycle that idle drops.

Top module: `ccu_branch_gate`

## Requirements
- R1: After reset, every branch register reads 0x0000_0001 (run on, power-down off, divide by one), and every branch strobes on every cycle while its base clock is on and its idle input is low.
- R2: Register layout: bit 0 is run and bit 1 is power-down. Both read back as written. All other bits read zero, except bit 27 on branches that have a divider. Writing bit 0 as one starts the branch.
- R3: Bit 5 is the divide-by-two request. It always reads back as zero. On a branch with a divider, bit 27 takes the requested value within three cycles of the write. While bit 27 is one, the branch strobes on exactly every other cycle.
- R4: On a branch without a divider, writes to bit 5 have no effect, bit 27 reads zero, and the branch keeps strobing every cycle.
- R5: A write that clears bit 0 while the branch has run=1 and stored power-down=0 is ignored entirely. If power-down was already set by an earlier write, the run-clearing write is accepted and the branch stops strobing.
- R6: With power-down=1 and run=1, a high idle input suppresses the branch strobes, and the strobes return in the same cycle that idle goes low. With power-down=0, the idle input has no effect.
- R7: While a group's bus branch (local index 0) has run=0, no other branch of that group strobes, whatever its run bit. The other groups are unaffected.
- R8: An access to a branch whose group base enable is low returns the error flag and leaves the register unchanged. No branch in that group strobes while its base enable is low.
- R9: An access to a word index at or beyond the branch count, or to an address that is not word-aligned, returns the error flag with read data zero.
- R10: Every read or write gets ready high for exactly one cycle, in the cycle after the access is presented. Error and read data are valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base-clock domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 32 | Byte address; branch n sits at word n |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | One-cycle response strobe |
| bus_err | output | 1 | Error response, valid with bus_ready |
| base_en | input | NUM_GROUPS | Base clock on, one bit per group |
| periph_idle | input | NUM_GROUPS*BR_PER_GRP | Idle hint, one bit per branch |
| branch_ce | output | NUM_GROUPS*BR_PER_GRP | Branch clock-enable strobes |

## Verification
The bench builds the block with two groups of four branches, and only branches 2 and 6 have a divider. With this setup a divided branch and a plain branch share a group, so divider requests can be sent to both kinds and compared. Stopping bus branch 4 while group 0 keeps running shows that the bus gating stays inside its own group. Switching off only the second base enable lets the error path be checked next to a group that is still live.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  localparam int RUN_BIT  = 0;
  localparam int APD_BIT  = 1;
  localparam int DREQ_BIT = 5;
  localparam int DSTS_BIT = 27;

  // Read-back word for one branch register.
  function automatic logic [31:0] pack_cfg(input logic run, input logic apd, input logic sts);
    logic [31:0] w;
    w = '0;
    w[RUN_BIT]  = run;
    w[APD_BIT]  = apd;
    w[DSTS_BIT] = sts;
    return w;
  endfunction

  // A write is refused when it would stop a running branch that has not armed power-down.
  function automatic logic write_allowed(input logic run_cur, input logic apd_cur, input logic run_new);
    return !(run_cur && !apd_cur && !run_new);
  endfunction

  // Strobe equation for one branch.
  function automatic logic strobe(input logic base_on, input logic run, input logic bus_ok,
                                  input logic apd, input logic idle, input logic sts, input logic ph);
    return base_on && run && bus_ok && !(apd && idle) && (!sts || ph);
  endfunction
endpackage

// File: rtl/ccu_addr_dec.sv
module ccu_addr_dec #(
  parameter int NUM_BR = 8,
  localparam int IDX_W = (NUM_BR > 1) ? $clog2(NUM_BR) : 1
) (
  input  logic [31:0]      addr,
  output logic [IDX_W-1:0] idx,
  output logic             hit
);
  assign idx = addr[2 +: IDX_W];
  assign hit = (addr[1:0] == 2'b00) && (addr[31:2] < 30'(NUM_BR));
endmodule

// File: rtl/ccu_branch.sv
module ccu_branch
  import ccu_pkg::*;
#(
  parameter bit HAS_DIV = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic base_on,
  input  logic bus_ok,
  input  logic idle,
  input  logic wr,
  input  logic wr_run,
  input  logic wr_apd,
  input  logic wr_dreq,
  output logic run,
  output logic apd,
  output logic sts,
  output logic ce
);
  logic run_q, apd_q;
  logic ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b1;
      apd_q <= 1'b0;
    end else if (wr && write_allowed(run_q, apd_q, wr_run)) begin
      run_q <= wr_run;
      apd_q <= wr_apd;
    end
  end

  generate
    if (HAS_DIV) begin : g_div
      logic req_q, sts_q, ph_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          req_q <= 1'b0;
          sts_q <= 1'b0;
          ph_q  <= 1'b0;
        end else begin
          if (wr && write_allowed(run_q, apd_q, wr_run)) req_q <= wr_dreq;
          if (base_on) ph_q <= ~ph_q;
          // status follows the request only on a divided-enable edge
          if (base_on && ph_q) sts_q <= req_q;
        end
      end
      assign sts = sts_q;
      assign ph  = ph_q;
    end else begin : g_nodiv
      logic unused_dreq;
      assign unused_dreq = wr_dreq;
      assign sts = 1'b0;
      assign ph  = 1'b1;
    end
  endgenerate

  assign run = run_q;
  assign apd = apd_q;
  assign ce  = strobe(base_on, run_q, bus_ok, apd_q, idle, sts, ph);
endmodule

// File: rtl/ccu_resp.sv
module ccu_resp (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        rd,
  input  logic        ok,
  input  logic [31:0] word,
  output logic        ready,
  output logic        err,
  output logic [31:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      ready <= req;
      err   <= req && !ok;
      rdata <= (rd && ok) ? word : '0;
    end
  end
endmodule

// File: rtl/ccu_branch_gate.sv
module ccu_branch_gate
  import ccu_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int BR_PER_GRP = 4,
  parameter logic [NUM_GROUPS*BR_PER_GRP-1:0] DIV_MASK = 8'b0100_0100,
  localparam int NUM_BR = NUM_GROUPS * BR_PER_GRP,
  localparam int IDX_W  = (NUM_BR > 1) ? $clog2(NUM_BR) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [31:0]           bus_addr,
  input  logic [31:0]           bus_wdata,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  output logic [31:0]           bus_rdata,
  output logic                  bus_ready,
  output logic                  bus_err,
  input  logic [NUM_GROUPS-1:0] base_en,
  input  logic [NUM_BR-1:0]     periph_idle,
  output logic [NUM_BR-1:0]     branch_ce
);
  logic [IDX_W-1:0]  idx;
  logic              hit;
  logic              base_sel;
  logic [31:0]       rd_word;
  logic [NUM_BR-1:0] run_q, apd_q, sts_q, wr_sel;
  logic              acc_req, acc_ok, acc_err_ev, wr_ok_ev;
  logic              unused_wdata;

  assign unused_wdata = ^{bus_wdata[31:6], bus_wdata[4:2]};

  ccu_addr_dec #(.NUM_BR(NUM_BR)) u_dec (.addr(bus_addr), .idx(idx), .hit(hit));

  always_comb begin
    base_sel = 1'b0;
    rd_word  = '0;
    for (int i = 0; i < NUM_BR; i++) begin
      if (hit && idx == IDX_W'(i)) begin
        base_sel = base_en[i / BR_PER_GRP];
        rd_word  = pack_cfg(run_q[i], apd_q[i], sts_q[i]);
      end
    end
  end

  assign acc_req    = bus_wr || bus_rd;
  assign acc_ok     = hit && base_sel;
  assign acc_err_ev = acc_req && !acc_ok;
  assign wr_ok_ev   = bus_wr && acc_ok;

  generate
    for (genvar i = 0; i < NUM_BR; i++) begin : g_br
      localparam int GRP = i / BR_PER_GRP;
      localparam int BUS = GRP * BR_PER_GRP;
      logic bus_ok;
      if (i == BUS) begin : g_bus
        assign bus_ok = 1'b1;
      end else begin : g_per
        assign bus_ok = run_q[BUS];
      end
      assign wr_sel[i] = wr_ok_ev && (idx == IDX_W'(i));
      ccu_branch #(.HAS_DIV(DIV_MASK[i])) u_br (
        .clk(clk), .rst_n(rst_n), .base_on(base_en[GRP]), .bus_ok(bus_ok),
        .idle(periph_idle[i]), .wr(wr_sel[i]),
        .wr_run(bus_wdata[RUN_BIT]), .wr_apd(bus_wdata[APD_BIT]), .wr_dreq(bus_wdata[DREQ_BIT]),
        .run(run_q[i]), .apd(apd_q[i]), .sts(sts_q[i]), .ce(branch_ce[i])
      );
    end
  endgenerate

  ccu_resp u_resp (
    .clk(clk), .rst_n(rst_n), .req(acc_req), .rd(bus_rd && !bus_wr), .ok(acc_ok),
    .word(rd_word), .ready(bus_ready), .err(bus_err), .rdata(bus_rdata)
  );
endmodule

// File: rtl/ccu_branch_gate_chk.sv
module ccu_branch_gate_chk #(
  parameter int NUM_GROUPS = 2,
  parameter int BR_PER_GRP = 4,
  localparam int NUM_BR = NUM_GROUPS * BR_PER_GRP,
  localparam int IDX_W  = (NUM_BR > 1) ? $clog2(NUM_BR) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [31:0]           bus_addr,
  input logic [31:0]           bus_wdata,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic                  bus_ready,
  input logic [NUM_GROUPS-1:0] base_en,
  input logic [NUM_BR-1:0]     periph_idle,
  input logic [NUM_BR-1:0]     branch_ce,
  input logic [NUM_BR-1:0]     run_q,
  input logic [NUM_BR-1:0]     apd_q,
  input logic                  acc_err_ev
);
  logic [NUM_BR-1:0] v_bus, v_base, v_idle;
  logic [IDX_W-1:0]  widx;
  logic              wmap, unsafe_wr;

  always_comb begin
    for (int i = 0; i < NUM_BR; i++) begin
      v_bus[i]  = branch_ce[i] && (i % BR_PER_GRP != 0) && !run_q[(i / BR_PER_GRP) * BR_PER_GRP];
      v_base[i] = branch_ce[i] && !base_en[i / BR_PER_GRP];
      v_idle[i] = branch_ce[i] && apd_q[i] && periph_idle[i];
    end
  end

  assign widx      = bus_addr[2 +: IDX_W];
  assign wmap      = (bus_addr[1:0] == 2'b00) && (bus_addr[31:2] < 30'(NUM_BR));
  assign unsafe_wr = bus_wr && wmap && run_q[widx] && !apd_q[widx] && !bus_wdata[0];

  assert_ready_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) |=> bus_ready);
  assert_bus_gate_R7: assert property (@(posedge clk) disable iff (!rst_n) v_bus == '0);
  assert_base_off_R8: assert property (@(posedge clk) disable iff (!rst_n) v_base == '0);
  assert_err_no_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err_ev |=> ($stable(run_q) && $stable(apd_q)));
  assert_unsafe_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    unsafe_wr |=> (run_q == $past(run_q)));
  assert_idle_gate_R6: assert property (@(posedge clk) disable iff (!rst_n) v_idle == '0);
endmodule

bind ccu_branch_gate ccu_branch_gate_chk #(.NUM_GROUPS(NUM_GROUPS), .BR_PER_GRP(BR_PER_GRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_ready(bus_ready), .base_en(base_en), .periph_idle(periph_idle),
  .branch_ce(branch_ce), .run_q(run_q), .apd_q(apd_q), .acc_err_ev(acc_err_ev)
);

// File: tb/tb_ccu_branch_gate.sv
`timescale 1ns/1ps
module tb_ccu_branch_gate;
  localparam int NG = 2;
  localparam int BP = 4;
  localparam int NB = NG * BP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   bus_addr = '0, bus_wdata = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic          bus_ready, bus_err;
  logic [NG-1:0] base_en = '1;
  logic [NB-1:0] periph_idle = '0;
  logic [NB-1:0] branch_ce;

  int checks = 0;
  int errors = 0;
  logic        r_ready, r_err;
  logic [31:0] r_data;

  ccu_branch_gate #(.NUM_GROUPS(NG), .BR_PER_GRP(BP), .DIV_MASK(8'b0100_0100)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err),
    .base_en(base_en), .periph_idle(periph_idle), .branch_ce(branch_ce)
  );

  always #2 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    r_ready = bus_ready; r_err = bus_err;
  endtask

  task automatic bus_read(input logic [31:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    r_ready = bus_ready; r_err = bus_err; r_data = bus_rdata;
  endtask

  task automatic count_ce(input int b, output int n);
    n = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (branch_ce[b]) n++;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 ce after reset", 32'(branch_ce), 32'hFF);
    check("R10 no ready at idle", 32'(bus_ready), 0);
    for (int i = 0; i < NB; i++) begin
      bus_read(32'(i * 4));
      check("R1 reset value", r_data, 32'h1);
    end
  endtask

  task automatic t_div;
    int n;
    bus_write(32'h8, 32'h21);
    bus_read(32'h8);
    check("R3 bit5 reads zero", 32'(r_data[5]), 0);
    check("R2 run reads back", 32'(r_data[0]), 1);
    repeat (3) @(negedge clk);
    bus_read(32'h8);
    check("R3 status set", r_data, 32'h0800_0001);
    count_ce(2, n);
    check("R3 half rate", 32'(n), 4);
    bus_write(32'h8, 32'h1);
    repeat (3) @(negedge clk);
    bus_read(32'h8);
    check("R3 status cleared", r_data, 32'h1);
    count_ce(2, n);
    check("R3 full rate", 32'(n), 8);
  endtask

  task automatic t_nodiv;
    int n;
    bus_write(32'h4, 32'h21);
    repeat (3) @(negedge clk);
    bus_read(32'h4);
    check("R4 no status on plain branch", r_data, 32'h1);
    count_ce(1, n);
    check("R4 full rate", 32'(n), 8);
  endtask

  task automatic t_stop;
    bus_write(32'h4, 32'h0);
    bus_read(32'h4);
    check("R5 unsafe stop ignored", r_data, 32'h1);
    check("R5 still strobing", 32'(branch_ce[1]), 1);
    bus_write(32'h4, 32'h2);
    bus_read(32'h4);
    check("R5 combined write ignored", r_data, 32'h1);
    bus_write(32'h4, 32'h3);
    bus_read(32'h4);
    check("R2 power-down reads back", r_data, 32'h3);
    check("R5 armed still runs", 32'(branch_ce[1]), 1);
    bus_write(32'h4, 32'h2);
    bus_read(32'h4);
    check("R5 safe stop accepted", r_data, 32'h2);
    check("R5 stopped", 32'(branch_ce[1]), 0);
    bus_write(32'h4, 32'h1);
    @(negedge clk);
    check("R2 restart", 32'(branch_ce[1]), 1);
  endtask

  task automatic t_idle;
    @(negedge clk);
    periph_idle[3] = 1'b1;
    #1;
    check("R6 idle ignored without power-down", 32'(branch_ce[3]), 1);
    bus_write(32'h0C, 32'h3);
    check("R6 idle suppresses", 32'(branch_ce[3]), 0);
    periph_idle[3] = 1'b0;
    #1;
    check("R6 resumes at once", 32'(branch_ce[3]), 1);
    bus_write(32'h0C, 32'h1);
  endtask

  task automatic t_bus;
    bus_write(32'h10, 32'h3);
    bus_write(32'h10, 32'h2);
    @(negedge clk);
    check("R7 group1 silenced", 32'(branch_ce[7:4]), 0);
    check("R7 group0 unaffected", 32'(branch_ce[3:0]), 32'hF);
    bus_read(32'h14);
    check("R7 peripheral run kept", r_data, 32'h1);
    bus_write(32'h10, 32'h1);
    @(negedge clk);
    check("R7 group1 back", 32'(branch_ce[7:4]), 32'hF);
  endtask

  task automatic t_base;
    @(negedge clk);
    base_en[1] = 1'b0;
    #1;
    check("R8 group off no strobes", 32'(branch_ce[7:4]), 0);
    bus_write(32'h14, 32'h3);
    check("R8 write error", 32'(r_err), 1);
    bus_read(32'h14);
    check("R8 read error", 32'(r_err), 1);
    check("R8 read data zero", r_data, 0);
    base_en[1] = 1'b1;
    bus_read(32'h14);
    check("R8 no update", r_data, 32'h1);
    check("R8 error cleared", 32'(r_err), 0);
  endtask

  task automatic t_unmapped;
    bus_read(32'h20);
    check("R9 out of range error", 32'(r_err), 1);
    check("R9 out of range data", r_data, 0);
    bus_write(32'h6, 32'h0);
    check("R9 misaligned error", 32'(r_err), 1);
    bus_read(32'h100);
    check("R9 far error", 32'(r_err), 1);
    @(negedge clk);
    check("R9 strobes undisturbed", 32'(branch_ce), 32'hFF);
  endtask

  task automatic t_ready;
    @(negedge clk);
    bus_addr = 32'h0; bus_rd = 1'b1;
    #1;
    check("R10 not ready same cycle", 32'(bus_ready), 0);
    @(negedge clk);
    bus_rd = 1'b0;
    check("R10 ready next cycle", 32'(bus_ready), 1);
    check("R10 data with ready", bus_rdata, 32'h1);
    @(negedge clk);
    check("R10 ready one cycle", 32'(bus_ready), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_div();
    t_nodiv();
    t_stop();
    t_idle();
    t_bus();
    t_base();
    t_unmapped();
    t_ready();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule